// File: doc/BRIEF.md
# Paged 32-bit Register Bridge for 16-bit Management Accesses

This block lets a management host that can only issue 16-bit register reads and writes (clause-22 style: a 5-bit device address, a 5-bit register number, 16 bits of data) reach a 32-bit internal register space. The bridge answers at exactly one device address. Behind that address it presents a page register, a set of sixteen low-half word slots and a single high-half slot. It builds full 32-bit transfers on an internal synchronous request/acknowledge bus from these pieces.

The internal byte address is made of three fields. The page register supplies bits 15:6. The register number of a low-half access (0x00 to 0x0F) supplies bits 5:2. Bits 1:0 are always zero, and every bit above the page field is also zero. A write takes three steps: set the page, write the low half, then write the high half. Only the high-half write starts the 32-bit internal write. A read also takes three steps: set the page, read the low half, then read the high half. The low-half read performs the 32-bit internal read and keeps the upper half, and the high-half read returns that kept value.

The host sees the internal bus's wait states through a ready output. While ready is low, new accesses are not accepted. The management frame decoder and the internal register contents are outside the block.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page register is 0, `mg_ready` is 1, `ib_req` is 0 and `mg_rdata` is 0.
- R2: An access is accepted only if `mg_valid` and `mg_ready` are both high and `mg_phy` equals 0x1F. An access to any other device address changes no state and starts no internal transfer.
- R3: A write to register 0x1F loads the page register from `mg_wdata[9:0]`. A read of register 0x1F returns the page register zero-extended to 16 bits.
- R4: A write to a register from 0x00 to 0x0F stores the 16-bit data and the slot number `mg_reg[3:0]`, and it starts no internal transfer.
- R5: A write to register 0x10 starts exactly one internal write. Its address is {16'b0, page, stored slot, 2'b00} and its data is {`mg_wdata`, stored low half}.
- R6: A read of a register from 0x00 to 0x0F starts exactly one internal read at {16'b0, page, `mg_reg[3:0]`, 2'b00}. It returns data bits 15:0 and keeps bits 31:16. Each later read of register 0x10 returns the kept half and starts no internal transfer.
- R7: After an access that starts an internal transfer, `mg_ready` is low from the next cycle until the cycle after `ib_ack`, which is wait states + 1 cycles in all. Accesses offered while `mg_ready` is low are ignored.
- R8: While `ib_req` is high and `ib_ack` is low, `ib_addr`, `ib_we` and `ib_wdata` hold their values. `ib_req` falls in the cycle after `ib_ack`.
- R9: The page register keeps its value across any number of low-half and high-half accesses until register 0x1F is written again.
- R10: Writes to registers 0x11 to 0x1E have no effect, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mg_valid | input | 1 | Decoded management access strobe |
| mg_write | input | 1 | 1 = write, 0 = read |
| mg_phy | input | 5 | Device address of the access |
| mg_reg | input | 5 | Register number of the access |
| mg_wdata | input | 16 | Write data |
| mg_rdata | output | 16 | Read data, valid once `mg_ready` is high again |
| mg_ready | output | 1 | Bridge can accept an access |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write enable |
| ib_addr | output | 32 | Internal byte address |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data, valid with `ib_ack` |
| ib_ack | input | 1 | Internal bus completion |

## Verification
The assertions check, on every cycle, the rules of the internal request: address, direction and data stay stable until acknowledge, the request drops after acknowledge, addresses are word-aligned with zero upper bits, and a request starts only after an accepted access to the bridge's own device address. The bench scenarios check everything that depends on data flowing through the three-step sequences. They show the page and slot landing in the right address bits, the high half pairing with the stored low half, the kept upper half being returned, the length of the ready-low window for several wait-state counts, and accesses to foreign addresses, during busy periods or to unused registers leaving state unchanged.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_PAGE_WR,
      ACC_PAGE_RD,
      ACC_LO_WR,
      ACC_LO_RD,
      ACC_HI_WR,
      ACC_HI_RD,
      ACC_VOID_RD
   } acc_e;
endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
   import mpb_pkg::*;
#(
   parameter int          REG_W    = 5,
   parameter int          SLOT_W   = 4,
   parameter logic [4:0]  PHY_ADDR = 5'h1f,
   parameter logic [4:0]  PAGE_REG = 5'h1f,
   parameter logic [4:0]  HIGH_REG = 5'h10
) (
   input  logic             valid,
   input  logic             ready,
   input  logic             write,
   input  logic [4:0]       phy,
   input  logic [REG_W-1:0] regn,
   output acc_e             acc
);
   localparam int NSLOT = 1 << SLOT_W;

   logic hit;
   assign hit = valid && ready && (phy == PHY_ADDR);

   always_comb begin
      acc = ACC_NONE;
      if (hit) begin
         if (regn == PAGE_REG)             acc = write ? ACC_PAGE_WR : ACC_PAGE_RD;
         else if (regn == HIGH_REG)        acc = write ? ACC_HI_WR   : ACC_HI_RD;
         else if (int'(regn) < NSLOT)      acc = write ? ACC_LO_WR   : ACC_LO_RD;
         else if (!write)                  acc = ACC_VOID_RD;
      end
   end
endmodule

// File: rtl/mpb_stage.sv
module mpb_stage
   import mpb_pkg::*;
#(
   parameter int MG_W   = 16,
   parameter int PAGE_W = 10,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc,
   input  logic [MG_W-1:0]   wdata,
   input  logic [SLOT_W-1:0] slot_in,
   input  logic              rd_done,
   input  logic [MG_W-1:0]   rd_upper,
   output logic [PAGE_W-1:0] page_q,
   output logic [SLOT_W-1:0] slot_q,
   output logic [MG_W-1:0]   lo_q,
   output logic [MG_W-1:0]   hi_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         slot_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         if (acc == ACC_PAGE_WR) page_q <= wdata[PAGE_W-1:0];
         if (acc == ACC_LO_WR) begin
            lo_q   <= wdata;
            slot_q <= slot_in;
         end
         if (rd_done) hi_q <= rd_upper;
      end
   end
endmodule

// File: rtl/mpb_bus_seq.sv
module mpb_bus_seq
   import mpb_pkg::*;
#(
   parameter int MG_W   = 16,
   parameter int PAGE_W = 10,
   parameter int SLOT_W = 4,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc,
   input  logic [MG_W-1:0]   wdata,
   input  logic [SLOT_W-1:0] slot_in,
   input  logic [PAGE_W-1:0] page_q,
   input  logic [SLOT_W-1:0] slot_q,
   input  logic [MG_W-1:0]   lo_q,
   input  logic [MG_W-1:0]   hi_q,
   input  logic [2*MG_W-1:0] ib_rdata,
   input  logic              ib_ack,
   output logic              ib_req,
   output logic              ib_we,
   output logic [ADDR_W-1:0] ib_addr,
   output logic [2*MG_W-1:0] ib_wdata,
   output logic [MG_W-1:0]   mg_rdata,
   output logic              rd_done
);
   localparam int BASE_W = PAGE_W + SLOT_W + 2;

   logic [SLOT_W-1:0] slot_sel;
   logic [BASE_W-1:0] base;
   logic [ADDR_W-1:0] addr_nxt;
   logic              done;

   assign slot_sel = (acc == ACC_LO_RD) ? slot_in : slot_q;
   assign base     = {page_q, slot_sel, 2'b00};

   generate
      if (ADDR_W > BASE_W) begin : g_pad
         assign addr_nxt = {{(ADDR_W-BASE_W){1'b0}}, base};
      end else begin : g_exact
         assign addr_nxt = base;
      end
   endgenerate

   assign done    = ib_req && ib_ack;
   assign rd_done = done && !ib_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ib_req   <= 1'b0;
         ib_we    <= 1'b0;
         ib_addr  <= '0;
         ib_wdata <= '0;
         mg_rdata <= '0;
      end else if (done) begin
         ib_req <= 1'b0;
         if (!ib_we) mg_rdata <= ib_rdata[MG_W-1:0];
      end else begin
         unique case (acc)
            ACC_HI_WR: begin
               ib_req   <= 1'b1;
               ib_we    <= 1'b1;
               ib_addr  <= addr_nxt;
               ib_wdata <= {wdata, lo_q};
            end
            ACC_LO_RD: begin
               ib_req  <= 1'b1;
               ib_we   <= 1'b0;
               ib_addr <= addr_nxt;
            end
            ACC_PAGE_RD: mg_rdata <= {{(MG_W-PAGE_W){1'b0}}, page_q};
            ACC_HI_RD:   mg_rdata <= hi_q;
            ACC_VOID_RD: mg_rdata <= '0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
   import mpb_pkg::*;
#(
   parameter int          MG_W     = 16,
   parameter int          REG_W    = 5,
   parameter int          PAGE_W   = 10,
   parameter int          SLOT_W   = 4,
   parameter int          ADDR_W   = 32,
   parameter logic [4:0]  PHY_ADDR = 5'h1f,
   parameter logic [4:0]  PAGE_REG = 5'h1f,
   parameter logic [4:0]  HIGH_REG = 5'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mg_valid,
   input  logic              mg_write,
   input  logic [4:0]        mg_phy,
   input  logic [REG_W-1:0]  mg_reg,
   input  logic [MG_W-1:0]   mg_wdata,
   output logic [MG_W-1:0]   mg_rdata,
   output logic              mg_ready,
   output logic              ib_req,
   output logic              ib_we,
   output logic [ADDR_W-1:0] ib_addr,
   output logic [2*MG_W-1:0] ib_wdata,
   input  logic [2*MG_W-1:0] ib_rdata,
   input  logic              ib_ack
);
   localparam int DATA_W = 2 * MG_W;
   localparam int BASE_W = PAGE_W + SLOT_W + 2;

   generate
      if (PAGE_W >= MG_W)          begin : g_chk_page $error("page field must be narrower than a management word"); end
      if (ADDR_W < BASE_W)         begin : g_chk_addr $error("internal address too narrow for page and slot"); end
      if ((1 << SLOT_W) > int'(HIGH_REG)) begin : g_chk_slot $error("slot registers overlap the high-half register"); end
      if (REG_W != 5)              begin : g_chk_reg  $error("register number must be 5 bits"); end
   endgenerate

   acc_e              acc;
   logic [PAGE_W-1:0] page_q;
   logic [SLOT_W-1:0] slot_q;
   logic [MG_W-1:0]   lo_q;
   logic [MG_W-1:0]   hi_q;
   logic              rd_done;

   assign mg_ready = !ib_req;

   mpb_decode #(
      .REG_W(REG_W), .SLOT_W(SLOT_W), .PHY_ADDR(PHY_ADDR),
      .PAGE_REG(PAGE_REG), .HIGH_REG(HIGH_REG)
   ) u_decode (
      .valid(mg_valid), .ready(mg_ready), .write(mg_write),
      .phy(mg_phy), .regn(mg_reg), .acc(acc)
   );

   mpb_stage #(.MG_W(MG_W), .PAGE_W(PAGE_W), .SLOT_W(SLOT_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(mg_wdata),
      .slot_in(mg_reg[SLOT_W-1:0]), .rd_done(rd_done),
      .rd_upper(ib_rdata[DATA_W-1:MG_W]),
      .page_q(page_q), .slot_q(slot_q), .lo_q(lo_q), .hi_q(hi_q)
   );

   mpb_bus_seq #(.MG_W(MG_W), .PAGE_W(PAGE_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(mg_wdata),
      .slot_in(mg_reg[SLOT_W-1:0]), .page_q(page_q), .slot_q(slot_q),
      .lo_q(lo_q), .hi_q(hi_q), .ib_rdata(ib_rdata), .ib_ack(ib_ack),
      .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
      .mg_rdata(mg_rdata), .rd_done(rd_done)
   );
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
   parameter int          MG_W     = 16,
   parameter int          PAGE_W   = 10,
   parameter int          SLOT_W   = 4,
   parameter int          ADDR_W   = 32,
   parameter logic [4:0]  PHY_ADDR = 5'h1f
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mg_valid,
   input logic [4:0]        mg_phy,
   input logic              mg_ready,
   input logic              ib_req,
   input logic              ib_ack,
   input logic              ib_we,
   input logic [ADDR_W-1:0] ib_addr,
   input logic [2*MG_W-1:0] ib_wdata
);
   localparam int BASE_W = PAGE_W + SLOT_W + 2;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ib_req && !ib_ack |=> ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)); // R8

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ib_req && ib_ack |=> !ib_req); // R8

   AST_REQ_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ib_req) |-> $past(mg_valid && mg_ready && (mg_phy == PHY_ADDR))); // R2

   AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      ib_req |-> (ib_addr[1:0] == 2'b00) && ((ib_addr >> BASE_W) == '0)); // R5

   AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ib_req) |-> !mg_ready); // R7
endmodule

bind mdio_page_bridge mpb_checker #(
   .MG_W(MG_W), .PAGE_W(PAGE_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .PHY_ADDR(PHY_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mg_valid(mg_valid), .mg_phy(mg_phy),
   .mg_ready(mg_ready), .ib_req(ib_req), .ib_ack(ib_ack), .ib_we(ib_we),
   .ib_addr(ib_addr), .ib_wdata(ib_wdata)
);

// File: tb/mdio_page_bridge_tb.sv
`timescale 1ns/1ps
module mdio_page_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mg_valid = 1'b0;
   logic        mg_write = 1'b0;
   logic [4:0]  mg_phy = '0;
   logic [4:0]  mg_reg = '0;
   logic [15:0] mg_wdata = '0;
   logic [15:0] mg_rdata;
   logic        mg_ready;
   logic        ib_req, ib_we, ib_ack;
   logic [31:0] ib_addr, ib_wdata, ib_rdata;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // test register file with programmable wait states
   logic [31:0] mem [64];
   int          wait_n = 0;
   int          wcnt = 0;
   int          n_bus = 0;
   logic [31:0] last_addr = '0;
   logic [31:0] last_wdata = '0;
   logic        last_we = 1'b0;

   always #4 clk = ~clk;

   mdio_page_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .mg_valid(mg_valid), .mg_write(mg_write),
      .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_wdata(mg_wdata), .mg_rdata(mg_rdata),
      .mg_ready(mg_ready), .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr),
      .ib_wdata(ib_wdata), .ib_rdata(ib_rdata), .ib_ack(ib_ack)
   );

   assign ib_ack   = ib_req && (wcnt == wait_n);
   assign ib_rdata = mem[ib_addr[7:2]];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (ib_req && ib_ack) begin
         wcnt       <= 0;
         n_bus      <= n_bus + 1;
         last_addr  <= ib_addr;
         last_we    <= ib_we;
         last_wdata <= ib_wdata;
         if (ib_we) mem[ib_addr[7:2]] <= ib_wdata;
      end else if (ib_req) begin
         wcnt <= wcnt + 1;
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(negedge clk) if (cyc > 50000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected < 50000", cyc);
      finish_run();
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [4:0] phy, input logic [4:0] rn,
                       input logic [15:0] wd, output logic [15:0] rd, output int busy);
      @(negedge clk);
      while (!mg_ready) @(negedge clk);
      mg_valid = 1'b1; mg_write = wr; mg_phy = phy; mg_reg = rn; mg_wdata = wd;
      @(negedge clk);
      mg_valid = 1'b0;
      busy = 0;
      while (!mg_ready) begin busy++; @(negedge clk); end
      rd = mg_rdata;
   endtask

   task automatic wr16(input logic [4:0] rn, input logic [15:0] wd);
      logic [15:0] d; int b;
      xfer(1'b1, 5'h1f, rn, wd, d, b);
   endtask

   task automatic rd16(input logic [4:0] rn, output logic [15:0] rd);
      int b;
      xfer(1'b0, 5'h1f, rn, 16'h0, rd, b);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R1 ready", {31'b0, mg_ready}, 32'h1);
      check("R1 req", {31'b0, ib_req}, 32'h0);
      check("R1 rdata", {16'b0, mg_rdata}, 32'h0);
      rd16(5'h1f, d);
      check("R1 page", {16'b0, d}, 32'h0);
   endtask

   task automatic t_page();
      logic [15:0] d;
      wr16(5'h1f, 16'h0155);
      rd16(5'h1f, d);
      check("R3 page load", {16'b0, d}, 32'h0155);
      wr16(5'h1f, 16'hffff);
      rd16(5'h1f, d);
      check("R3 page truncate", {16'b0, d}, 32'h03ff);
   endtask

   task automatic t_write();
      int nb;
      wr16(5'h1f, 16'h0001);
      nb = n_bus;
      wr16(5'h03, 16'hbeef);
      check("R4 no bus on low write", n_bus, nb);
      wait_n = 2;
      wr16(5'h10, 16'hcafe);
      check("R5 one write", n_bus, nb + 1);
      check("R5 addr", last_addr, 32'h0000_004c);
      check("R5 data", last_wdata, 32'hcafe_beef);
      check("R5 we", {31'b0, last_we}, 32'h1);
   endtask

   task automatic t_read();
      logic [15:0] d; int nb; int b;
      wait_n = 3;
      nb = n_bus;
      xfer(1'b0, 5'h1f, 5'h03, 16'h0, d, b);
      check("R6 low half", {16'b0, d}, 32'h0000_beef);
      check("R6 one read", n_bus, nb + 1);
      check("R6 read addr", last_addr, 32'h0000_004c);
      check("R7 busy cycles w3", b, 4);
      rd16(5'h10, d);
      check("R6 high half", {16'b0, d}, 32'h0000_cafe);
      rd16(5'h10, d);
      check("R6 high repeat", {16'b0, d}, 32'h0000_cafe);
      check("R6 no bus on high read", n_bus, nb + 1);
      wait_n = 0;
      xfer(1'b0, 5'h1f, 5'h03, 16'h0, d, b);
      check("R7 busy cycles w0", b, 1);
   endtask

   task automatic t_foreign();
      logic [15:0] d; int nb; int b;
      wr16(5'h1f, 16'h0002);
      nb = n_bus;
      xfer(1'b1, 5'h05, 5'h1f, 16'h0003, d, b);
      xfer(1'b0, 5'h1e, 5'h00, 16'h0, d, b);
      xfer(1'b1, 5'h00, 5'h10, 16'h1234, d, b);
      check("R2 no bus from foreign", n_bus, nb);
      rd16(5'h1f, d);
      check("R2 page untouched", {16'b0, d}, 32'h0002);
   endtask

   task automatic t_busy_ignored();
      logic [15:0] d; int nb;
      wait_n = 5;
      nb = n_bus;
      @(negedge clk);
      mg_valid = 1'b1; mg_write = 1'b0; mg_phy = 5'h1f; mg_reg = 5'h00;
      @(negedge clk);
      mg_write = 1'b1; mg_reg = 5'h1f; mg_wdata = 16'h0077;
      @(negedge clk);
      mg_write = 1'b1; mg_reg = 5'h10; mg_wdata = 16'h5555;
      @(negedge clk);
      mg_valid = 1'b0;
      while (!mg_ready) @(negedge clk);
      check("R7 one access only", n_bus, nb + 1);
      rd16(5'h1f, d);
      check("R7 page unchanged while busy", {16'b0, d}, 32'h0002);
      wait_n = 1;
   endtask

   task automatic t_void();
      logic [15:0] d;
      wr16(5'h15, 16'h00aa);
      rd16(5'h15, d);
      check("R10 unused read zero", {16'b0, d}, 32'h0);
      rd16(5'h1e, d);
      check("R10 unused read zero 1e", {16'b0, d}, 32'h0);
      rd16(5'h1f, d);
      check("R10 page kept", {16'b0, d}, 32'h0002);
   endtask

   task automatic t_page_hold();
      logic [15:0] d;
      wr16(5'h00, 16'h1111);
      wr16(5'h10, 16'h2222);
      check("R9 addr page 2 slot 0", last_addr, 32'h0000_0080);
      wr16(5'h0f, 16'h3333);
      wr16(5'h10, 16'h4444);
      check("R9 addr page 2 slot 15", last_addr, 32'h0000_00bc);
      rd16(5'h00, d);
      check("R9 readback low", {16'b0, d}, 32'h1111);
      rd16(5'h10, d);
      check("R9 readback high", {16'b0, d}, 32'h2222);
      rd16(5'h1f, d);
      check("R9 page still 2", {16'b0, d}, 32'h0002);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_page();
      t_write();
      t_read();
      t_foreign();
      t_busy_ignored();
      t_void();
      t_page_hold();
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule